// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with a small register file on a synchronous 16-bit write bus and a combinational read port. A prescaler turns the core clock into coarse ticks. A 10-bit remaining count, loaded from the period register, drops by one on each tick.

When the count runs out the first time, the block sets an expiry flag and pulses one management interrupt: SMI when `smiSelect` is high, otherwise NMI. It then reloads and counts again. If the count runs out a second time with no software kick in between, the block records the second expiry and a boot flag. It then asks for a system reset, unless a strap input or a configuration input inhibits that.

Software keeps the system alive by writing the kick register. Two mailbox bytes, two note bytes, a second control word and a software-interrupt byte complete the map.

Register map (word index on `busAddr`):

| Index | Register | Width |
|---|---|---|
| 0 | kick / live count | 16 |
| 1 | period | 10 |
| 2 | control A | 16 |
| 3 | control B | 16 |
| 4 | status A | 16 |
| 5 | status B | 16 |
| 6 | mailbox in | 8 |
| 7 | mailbox out | 8 |
| 8 | note 1 | 8 |
| 9 | note 2 | 8 |
| 10 | software interrupt | 8 |

Bit fields:
- Control A: bit 0 is halt and bit 1 is lock. No other bit is writable.
- Status A: bit 0 is expiry, bit 1 is mailbox-in and bit 2 is mailbox-out.
- Status B: bit 0 is second expiry and bit 1 is boot.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset these registers read back as follows, and no pulse appears while the timer is stopped:

  | Register | Value |
  |---|---|
  | period | 0x0004 |
  | control B | 0x0008 |
  | software interrupt | 0x0003 |
  | every other register | 0 |

- R2: The count runs only when halt (control A bit 0) is clear and the period is greater than 1. A write to control A with halt clear and the period above 1 starts a fresh count from the period. Any other write to control A stops the count. A period of 0 or 1 never starts it.
- R3: Writes take effect at the write edge. The first expiry happens period × TICK_DIV cycles after the edge that started the count. It sets status A bit 0.
- R4: On an expiry that does not reset, one pulse lasting one cycle appears, on `smiPulse` if `smiSelect` is high, otherwise on `nmiPulse`. The count then restarts from the period.
- R5: Every second consecutive expiry sets status B bits 0 and 1. It then clears the count of consecutive expiries.
- R6: If `strapNoReboot` and `noRebootCfg` are both low at a second expiry, the following happens:
  - `resetReq` pulses for one cycle and no NMI is raised.
  - The count stops.
  - The kick register reads 0.
- R7: If either inhibit input is high at a second expiry, it behaves like R4.
- R8: A write to the kick register clears the count of consecutive expiries. If counting is allowed (R2), the write restarts the count from the period. If not, the written value is stored and reads back.
- R9: Lock (control A bit 1) can be set by software but is only cleared by reset.
- R10: A write to mailbox in stores the low byte, sets status A bit 1 and pulses SMI whatever `smiSelect` is. A write to mailbox out stores the low byte and sets status A bit 2, with no pulse.
- R11: A write to status A or status B replaces it with the written value masked to the implemented bits: 0x0007 for status A and 0x0003 for status B.
- R12: While counting, the kick register reads as the stored upper six bits followed by the remaining tick count in bits 9:0.
- R13: A write to the kick register or to control A on the very edge of an expiry cancels that expiry: no flag and no pulse. A status A write on an expiry edge still leaves bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for one cycle |
| busAddr | input | 4 | Register word index |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data for `busAddr`, combinational |
| strapNoReboot | input | 1 | Strap; high inhibits the reset request |
| noRebootCfg | input | 1 | Configuration; high inhibits the reset request |
| smiSelect | input | 1 | High steers expiry interrupts to SMI, low to NMI |
| smiPulse | output | 1 | Management interrupt pulse |
| nmiPulse | output | 1 | Non-maskable interrupt pulse |
| resetReq | output | 1 | System reset request pulse |

## Verification
A software kick and a counter expiry can land on the same clock edge. So can a status write and an expiry. The bench computes the exact expiry edge from period × TICK_DIV and places a kick write on that edge. It then expects no pulse, a clear expiry flag and a fresh first expiry one full period later. It next places a status-clearing write on the following expiry edge and expects both the interrupt pulse and status A bit 0 to survive.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  // register word index map
  localparam logic [ADDR_W-1:0] RA_KICK   = 4'd0;
  localparam logic [ADDR_W-1:0] RA_PERIOD = 4'd1;
  localparam logic [ADDR_W-1:0] RA_CTRLA  = 4'd2;
  localparam logic [ADDR_W-1:0] RA_CTRLB  = 4'd3;
  localparam logic [ADDR_W-1:0] RA_STATA  = 4'd4;
  localparam logic [ADDR_W-1:0] RA_STATB  = 4'd5;
  localparam logic [ADDR_W-1:0] RA_MBOXI  = 4'd6;
  localparam logic [ADDR_W-1:0] RA_MBOXO  = 4'd7;
  localparam logic [ADDR_W-1:0] RA_NOTE1  = 4'd8;
  localparam logic [ADDR_W-1:0] RA_NOTE2  = 4'd9;
  localparam logic [ADDR_W-1:0] RA_SWIRQ  = 4'd10;

  localparam int HALT_BIT    = 0;
  localparam int LOCK_BIT    = 1;
  localparam int STA_EXPIRED = 0;
  localparam int STA_MBOXI   = 1;
  localparam int STA_MBOXO   = 2;
  localparam int STB_SECOND  = 0;
  localparam int STB_BOOT    = 1;

  localparam logic [DATA_W-1:0] CTRLA_MASK = 16'h0003;
  localparam logic [DATA_W-1:0] STATA_MASK = 16'h0007;
  localparam logic [DATA_W-1:0] STATB_MASK = 16'h0003;
  localparam logic [DATA_W-1:0] LOCK_MASK  = 16'h0002;

  localparam logic [DATA_W-1:0] CTRLB_INIT  = 16'h0008;
  localparam logic [BYTE_W-1:0] SWIRQ_INIT  = 8'h03;
  localparam int                PERIOD_INIT = 4;

  typedef struct packed {
    logic wrKick;
    logic wrPeriod;
    logic wrCtrlA;
    logic wrCtrlB;
    logic wrStatA;
    logic wrStatB;
    logic wrMboxI;
    logic wrMboxO;
    logic wrNote1;
    logic wrNote2;
    logic wrSwIrq;
    logic startCnt;
    logic stopCnt;
    logic clrKick;
    logic setExpired;
    logic setSecond;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrHaltBit,
  input  logic              expireNow,
  input  logic              haltNow,
  input  logic              periodGt1,
  input  logic              strapNoReboot,
  input  logic              noRebootCfg,
  input  logic              smiSelect,
  output wdStrobe_t         strb,
  output logic              smiPulse,
  output logic              nmiPulse,
  output logic              resetReq
);
  logic secondPend;
  logic kickHit, allowCur, allowNew, expEvt, isSecond, doRst, irqEvt;

  always_comb begin
    strb = '0;
    strb.wrKick   = busWr && (busAddr == RA_KICK);
    strb.wrPeriod = busWr && (busAddr == RA_PERIOD);
    strb.wrCtrlA  = busWr && (busAddr == RA_CTRLA);
    strb.wrCtrlB  = busWr && (busAddr == RA_CTRLB);
    strb.wrStatA  = busWr && (busAddr == RA_STATA);
    strb.wrStatB  = busWr && (busAddr == RA_STATB);
    strb.wrMboxI  = busWr && (busAddr == RA_MBOXI);
    strb.wrMboxO  = busWr && (busAddr == RA_MBOXO);
    strb.wrNote1  = busWr && (busAddr == RA_NOTE1);
    strb.wrNote2  = busWr && (busAddr == RA_NOTE2);
    strb.wrSwIrq  = busWr && (busAddr == RA_SWIRQ);

    kickHit  = strb.wrKick || strb.wrCtrlA;
    allowCur = !haltNow && periodGt1;
    allowNew = !wrHaltBit && periodGt1;
    // a kick on the expiry edge wins over the expiry (R13)
    expEvt   = expireNow && !kickHit;
    isSecond = expEvt && secondPend;
    doRst    = isSecond && !strapNoReboot && !noRebootCfg;
    irqEvt   = expEvt && !doRst;

    strb.startCnt   = (strb.wrKick && allowCur) || (strb.wrCtrlA && allowNew) || irqEvt;
    strb.stopCnt    = (strb.wrCtrlA && !allowNew) || doRst;
    strb.clrKick    = doRst;
    strb.setExpired = expEvt;
    strb.setSecond  = isSecond;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secondPend <= 1'b0;
      smiPulse   <= 1'b0;
      nmiPulse   <= 1'b0;
      resetReq   <= 1'b0;
    end else begin
      if (strb.wrKick)  secondPend <= 1'b0;
      else if (expEvt)  secondPend <= !secondPend;
      smiPulse <= (irqEvt && smiSelect) || strb.wrMboxI;
      nmiPulse <= irqEvt && !smiSelect;
      resetReq <= doRst;
    end
  end

  AST_RST_NO_NMI: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !nmiPulse);  // R6
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);  // R6
endmodule

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int TICK_DIV = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrobe_t         strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              expireNow,
  output logic              haltNow,
  output logic              periodGt1,
  output logic              counting
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [CNT_W-1:0]  remCnt, period;
  logic              runFlag, tick;
  logic [DATA_W-1:0] kickReg, ctrlA, ctrlB, statA, statB, setA, setB;
  logic [BYTE_W-1:0] mboxI, mboxO, note1, note2, swIrq;

  assign tick      = runFlag && (preCnt == PRE_LAST);
  assign expireNow = tick && (remCnt <= CNT_W'(1));
  assign haltNow   = ctrlA[HALT_BIT];
  assign periodGt1 = period > CNT_W'(1);
  assign counting  = runFlag;

  // prescaler and countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runFlag <= 1'b0;
      preCnt  <= '0;
      remCnt  <= '0;
    end else if (strb.startCnt) begin
      runFlag <= 1'b1;
      preCnt  <= '0;
      remCnt  <= period;
    end else if (strb.stopCnt) begin
      runFlag <= 1'b0;
      preCnt  <= '0;
    end else if (runFlag) begin
      preCnt <= tick ? '0 : preCnt + PRE_W'(1);
      if (tick) remCnt <= remCnt - CNT_W'(1);
    end
  end

  always_comb begin
    setA = '0;
    setB = '0;
    setA[STA_EXPIRED] = strb.setExpired;
    setA[STA_MBOXI]   = strb.wrMboxI;
    setA[STA_MBOXO]   = strb.wrMboxO;
    setB[STB_SECOND]  = strb.setSecond;
    setB[STB_BOOT]    = strb.setSecond;
  end

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      kickReg <= '0;
      period  <= CNT_W'(PERIOD_INIT);
      ctrlA   <= '0;
      ctrlB   <= CTRLB_INIT;
      statA   <= '0;
      statB   <= '0;
      mboxI   <= '0;
      mboxO   <= '0;
      note1   <= '0;
      note2   <= '0;
      swIrq   <= SWIRQ_INIT;
    end else begin
      if (strb.startCnt)     kickReg <= DATA_W'(period);
      else if (strb.clrKick) kickReg <= '0;
      else if (strb.wrKick)  kickReg <= busWData;
      if (strb.wrPeriod) period <= busWData[CNT_W-1:0];
      if (strb.wrCtrlA)  ctrlA  <= (busWData & CTRLA_MASK) | (ctrlA & LOCK_MASK);
      if (strb.wrCtrlB)  ctrlB  <= busWData;
      statA <= (strb.wrStatA ? (busWData & STATA_MASK) : statA) | setA;
      statB <= (strb.wrStatB ? (busWData & STATB_MASK) : statB) | setB;
      if (strb.wrMboxI)  mboxI <= busWData[BYTE_W-1:0];
      if (strb.wrMboxO)  mboxO <= busWData[BYTE_W-1:0];
      if (strb.wrNote1)  note1 <= busWData[BYTE_W-1:0];
      if (strb.wrNote2)  note2 <= busWData[BYTE_W-1:0];
      if (strb.wrSwIrq)  swIrq <= busWData[BYTE_W-1:0];
    end
  end

  always_comb begin
    case (busAddr)
      RA_KICK:   busRData = runFlag ? {kickReg[DATA_W-1:CNT_W], remCnt} : kickReg;
      RA_PERIOD: busRData = DATA_W'(period);
      RA_CTRLA:  busRData = ctrlA;
      RA_CTRLB:  busRData = ctrlB;
      RA_STATA:  busRData = statA;
      RA_STATB:  busRData = statB;
      RA_MBOXI:  busRData = DATA_W'(mboxI);
      RA_MBOXO:  busRData = DATA_W'(mboxO);
      RA_NOTE1:  busRData = DATA_W'(note1);
      RA_NOTE2:  busRData = DATA_W'(note2);
      RA_SWIRQ:  busRData = DATA_W'(swIrq);
      default:   busRData = '0;
    endcase
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlA[LOCK_BIT]) |-> ctrlA[LOCK_BIT]);  // R9
  AST_RUN_START_OK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runFlag) |-> (period > CNT_W'(1)) && !ctrlA[HALT_BIT]);  // R2
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int TICK_DIV = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [3:0]  busAddr,
  input  logic [15:0] busWData,
  output logic [15:0] busRData,
  input  logic        strapNoReboot,
  input  logic        noRebootCfg,
  input  logic        smiSelect,
  output logic        smiPulse,
  output logic        nmiPulse,
  output logic        resetReq
);
  wdStrobe_t strb;
  logic expireNow, haltNow, periodGt1, counting;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .wrHaltBit(busWData[HALT_BIT]), .expireNow(expireNow), .haltNow(haltNow),
    .periodGt1(periodGt1), .strapNoReboot(strapNoReboot), .noRebootCfg(noRebootCfg),
    .smiSelect(smiSelect), .strb(strb), .smiPulse(smiPulse), .nmiPulse(nmiPulse),
    .resetReq(resetReq)
  );

  wdog_dpath #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .expireNow(expireNow), .haltNow(haltNow),
    .periodGt1(periodGt1), .counting(counting)
  );

  AST_RST_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !counting);  // R6
endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  localparam int DIV = 3;
  localparam int PER = 5;
  localparam int PD  = PER * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic strapNoReboot = 1'b1;
  logic noRebootCfg = 1'b0;
  logic smiSelect = 1'b1;
  logic smiPulse, nmiPulse, resetReq;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int lastEdge = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    logic  smi;
    logic  nmi;
    logic  rst;
    string tag;
  } ev_t;
  ev_t evQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_two_stage #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .strapNoReboot(strapNoReboot), .noRebootCfg(noRebootCfg),
    .smiSelect(smiSelect), .smiPulse(smiPulse), .nmiPulse(nmiPulse), .resetReq(resetReq)
  );

  task automatic push(input int at, input logic s, input logic n, input logic r, input string tag);
    ev_t e;
    e.at = at; e.smi = s; e.nmi = n; e.rst = r; e.tag = tag;
    evQ.push_back(e);
  endtask

  // monitor: compares pulse outputs against the expected queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (evQ.size() > 0 && evQ[0].at < cyc) begin
        nChk++; nFail++;
        $display("FAIL %s: pulse missed at edge %0d", evQ[0].tag, evQ[0].at);
        void'(evQ.pop_front());
      end
      if (evQ.size() > 0 && evQ[0].at == cyc) begin
        nChk++;
        if ({smiPulse, nmiPulse, resetReq} !== {evQ[0].smi, evQ[0].nmi, evQ[0].rst}) begin
          nFail++;
          $display("FAIL %s: smi/nmi/rst=%b%b%b expected %b%b%b at edge %0d", evQ[0].tag,
                   smiPulse, nmiPulse, resetReq, evQ[0].smi, evQ[0].nmi, evQ[0].rst, cyc);
        end
        void'(evQ.pop_front());
      end else if (smiPulse || nmiPulse || resetReq) begin
        nChk++; nFail++;
        $display("FAIL R1/R2/R10: unexpected pulse smi/nmi/rst=%b%b%b expected 000 at edge %0d",
                 smiPulse, nmiPulse, resetReq, cyc);
      end
    end
  end

  task automatic drv(input logic [3:0] a, input logic [15:0] d);
    busWr = 1'b1; busAddr = a; busWData = d;
    @(posedge clk);
    lastEdge = cyc + 1;
    #1 busWr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    drv(a, d);
  endtask

  task automatic waitUntil(input int e);
    @(negedge clk);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic wrAt(input int e, input logic [3:0] a, input logic [15:0] d);
    waitUntil(e - 1);
    drv(a, d);
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    nChk++;
    if (busRData !== exp) begin
      nFail++;
      $display("FAIL %s: reg %0d read %h expected %h", tag, a, busRData, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    if (evQ.size() != 0) begin
      nChk++; nFail++;
      $display("FAIL scoreboard: %0d expected pulses never seen, expected 0", evQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: run hung, expected completion");
    finishRun();
  end

  initial begin
    int e0, e1, e2, w;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(4'd0, 16'h0000, "R1");  rd(4'd1, 16'h0004, "R1");
    rd(4'd2, 16'h0000, "R1");  rd(4'd3, 16'h0008, "R1");
    rd(4'd4, 16'h0000, "R1");  rd(4'd5, 16'h0000, "R1");
    rd(4'd6, 16'h0000, "R1");  rd(4'd7, 16'h0000, "R1");
    rd(4'd8, 16'h0000, "R1");  rd(4'd9, 16'h0000, "R1");
    rd(4'd10, 16'h0003, "R1");
    idle(20);

    // R2: period 1 and 0 never start the count
    wr(4'd1, 16'd1); wr(4'd2, 16'h0000); idle(30);
    rd(4'd0, 16'h0000, "R2");
    // R8: kick write while not allowed stores the value
    wr(4'd0, 16'h1234);
    rd(4'd0, 16'h1234, "R8");
    wr(4'd1, 16'd0); wr(4'd2, 16'h0000); idle(30);
    rd(4'd0, 16'h1234, "R2");

    // R3/R4/R5/R7/R6 two-stage sequence
    wr(4'd1, 16'(PER));
    wr(4'd2, 16'h0000); e0 = lastEdge;
    push(e0 + PD, 1'b1, 1'b0, 1'b0, "R3");
    waitUntil(e0 + 7);
    rd(4'd0, 16'(PER - 2), "R12");
    waitUntil(e0 + PD + 1);
    rd(4'd4, 16'h0001, "R3");
    wr(4'd4, 16'hFFFF); rd(4'd4, 16'h0007, "R11");
    wr(4'd4, 16'h0000); rd(4'd4, 16'h0000, "R11");
    push(e0 + 2*PD, 1'b1, 1'b0, 1'b0, "R7");
    waitUntil(e0 + 2*PD + 1);
    rd(4'd5, 16'h0003, "R5");
    wr(4'd5, 16'hFFFC); rd(4'd5, 16'h0000, "R11");
    smiSelect = 1'b0;
    push(e0 + 3*PD, 1'b0, 1'b1, 1'b0, "R4");
    waitUntil(e0 + 3*PD + 1);
    rd(4'd5, 16'h0000, "R5");
    strapNoReboot = 1'b0;
    push(e0 + 4*PD, 1'b0, 1'b0, 1'b1, "R6");
    waitUntil(e0 + 4*PD + 1);
    rd(4'd0, 16'h0000, "R6");
    idle(40);
    rd(4'd5, 16'h0003, "R5");

    // R8: a kick clears the consecutive-expiry count
    smiSelect = 1'b1;
    wr(4'd5, 16'h0000);
    wr(4'd2, 16'h0000); e1 = lastEdge;
    push(e1 + PD, 1'b1, 1'b0, 1'b0, "R8");
    waitUntil(e1 + PD + 5);
    wr(4'd0, 16'h0000); w = lastEdge;
    push(w + PD, 1'b1, 1'b0, 1'b0, "R8");
    push(w + 2*PD, 1'b0, 1'b0, 1'b1, "R8");
    waitUntil(w + 2*PD + 1);
    rd(4'd0, 16'h0000, "R8");

    // R13: collisions on the expiry edge
    wr(4'd4, 16'h0000);
    wr(4'd2, 16'h0000); e2 = lastEdge;
    wrAt(e2 + PD, 4'd0, 16'h0000);
    push(e2 + 2*PD, 1'b1, 1'b0, 1'b0, "R13");
    rd(4'd4, 16'h0000, "R13");
    wrAt(e2 + 2*PD, 4'd4, 16'h0000);
    rd(4'd4, 16'h0001, "R13");
    wr(4'd2, 16'h0001);
    idle(40);
    rd(4'd0, 16'(PER), "R2");

    // R9 lock is sticky
    wr(4'd2, 16'h0003); rd(4'd2, 16'h0003, "R9");
    wr(4'd2, 16'h0000); rd(4'd2, 16'h0002, "R9");
    wr(4'd2, 16'h0001); rd(4'd2, 16'h0003, "R9");

    // R10 mailboxes
    smiSelect = 1'b0;
    @(negedge clk);
    push(cyc + 1, 1'b1, 1'b0, 1'b0, "R10");
    drv(4'd6, 16'h12A5);
    rd(4'd6, 16'h00A5, "R10");
    rd(4'd4, 16'h0003, "R10");
    wr(4'd7, 16'h003C);
    rd(4'd7, 16'h003C, "R10");
    rd(4'd4, 16'h0007, "R10");
    idle(10);

    finishRun();
  end
endmodule